// File: doc/BRIEF.md
# Refresh Interval Request Timer

This block counts clock cycles against a programmable interval and records a refresh request each time the interval runs out. It keeps recording requests whether or not the chip's own refresh engine is enabled. External logic can therefore serve refreshes through a request/acknowledge handshake, or the internal engine can serve them. Requests that are still outstanding are held and stacked until something retires them.

A single status pin reports one of two things. A mode bit, captured when the block is programmed, selects which one: either "a refresh is owed" or "an internal refresh cycle is running now". The interval counter can be zeroed from outside. To do this, the refresh strobe must be held high with the disable input low for a qualifying number of clock cycles, which stands for a minimum pulse time.

Top module: `refresh_req_timer`

## Requirements
- R1: With an interval value N, one request is recorded on every Nth rising clock edge counted from reset or from the last clear. An interval of 0 behaves like 1, so a request is recorded on every edge.
- R2: Requests keep being recorded while `rfsh_dis` is high. The disable input has no effect on the timer except to block the clear.
- R3: `mode_in` is captured on an edge where `prog_load` is high. With the mode at 0, `status_pin` is high whenever at least one request is outstanding. With the mode at 1, `status_pin` follows `rfsh_active` and nothing else.
- R4: An outstanding request stays recorded until it is serviced. An edge with `ext_ack` high services one request. An edge on which `rfsh_active` has just risen (it was low on the previous edge) also services one request.
- R5: Up to BACKLOG_MAX+1 requests can be outstanding: one pending plus BACKLOG_MAX in backlog. An expiry beyond that limit is dropped.
- R6: If `rfsh_strobe` is high and `rfsh_dis` is low on CLR_CYCLES consecutive edges, the interval counter reads zero after the last of those edges. It stays at zero while the condition holds. A shorter run has no effect on the counter, and a clear never removes outstanding requests.
- R7: Reset leaves the counter at zero, no request outstanding, and the mode at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_load | input | 1 | Programming strobe that captures `mode_in` |
| mode_in | input | 1 | Pin function: 0 = request pending, 1 = refresh in progress |
| interval | input | CNT_W | Refresh interval in clock cycles |
| rfsh_dis | input | 1 | Internal refresh disable, active high |
| rfsh_strobe | input | 1 | Refresh strobe, active high; used for the clear |
| ext_ack | input | 1 | Acknowledge for an externally served refresh |
| rfsh_active | input | 1 | High while an internal refresh cycle runs |
| status_pin | output | 1 | Status output, active high |

## Verification
The bench builds the block with an 8-bit interval, CLR_CYCLES = 3 and BACKLOG_MAX = 7. These values keep every interval short enough to sweep edge by edge, including 0 and 1. They also make the clear boundary, a run of 2 edges against a run of 3, cheap to reach. The backlog sweep lets between 1 and 10 intervals go by unacknowledged, then counts the acknowledges needed to drop the pin. That count shows the cap at 8 outstanding requests directly.

// File: rtl/refresh_req_timer.sv
module refresh_req_timer #(
  parameter int CNT_W       = 16,
  parameter int CLR_CYCLES  = 13,
  parameter int BACKLOG_MAX = 7,
  localparam int OWED_MAX   = BACKLOG_MAX + 1,
  localparam int OW         = $clog2(OWED_MAX + 1),
  localparam int HW         = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_load,
  input  logic             mode_in,
  input  logic [CNT_W-1:0] interval,
  input  logic             rfsh_dis,
  input  logic             rfsh_strobe,
  input  logic             ext_ack,
  input  logic             rfsh_active,
  output logic             status_pin
);

  logic [CNT_W-1:0] cnt;
  logic [HW-1:0]    hold;
  logic [OW-1:0]    owed;
  logic             mode_q, act_q;

  wire             clr_cond = rfsh_strobe & ~rfsh_dis;
  wire             clr      = clr_cond && (hold == HW'(CLR_CYCLES - 1));
  wire [CNT_W:0]   nxt      = {1'b0, cnt} + 1'b1;
  wire             expire   = !clr && (nxt >= {1'b0, interval});
  wire             act_rise = rfsh_active & ~act_q;
  wire             svc      = (ext_ack | act_rise) && (owed != '0);
  wire             add      = expire && (owed != OW'(OWED_MAX));

  assign status_pin = mode_q ? rfsh_active : (owed != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      hold   <= '0;
      owed   <= '0;
      mode_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      act_q <= rfsh_active;
      if (prog_load) mode_q <= mode_in;

      if (!clr_cond)   hold <= '0;
      else if (!clr)   hold <= hold + 1'b1;

      if (clr || expire) cnt <= '0;
      else               cnt <= nxt[CNT_W-1:0];

      owed <= owed + OW'(add) - OW'(svc);
    end
  end

  AST_OWED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(OWED_MAX)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (owed != '0) && !ext_ack && !act_rise |=> (owed != '0)); // R4

  AST_EXPIRY_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    expire && (owed != OW'(OWED_MAX)) && !ext_ack && !act_rise
      |=> owed == $past(owed) + OW'(1)); // R1

  AST_NO_SHORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && (CLR_CYCLES > 1) |-> $past(clr_cond)); // R6

  AST_CLEAR_KEEPS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !ext_ack && !act_rise |=> owed >= $past(owed)); // R6

endmodule

// File: tb/refresh_req_timer_test.sv
`timescale 1ns/1ps
module refresh_req_timer_test;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0, prog_load = 0, mode_in = 0;
  logic [CW-1:0] interval = '0;
  logic rfsh_dis = 0, rfsh_strobe = 0, ext_ack = 0, rfsh_active = 0;
  logic status_pin;
  int checks = 0, fails = 0, cyc = 0;

  refresh_req_timer #(.CNT_W(CW), .CLR_CYCLES(3), .BACKLOG_MAX(7)) uut (
    .clk(clk), .rst_n(rst_n), .prog_load(prog_load), .mode_in(mode_in),
    .interval(interval), .rfsh_dis(rfsh_dis), .rfsh_strobe(rfsh_strobe),
    .ext_ack(ext_ack), .rfsh_active(rfsh_active), .status_pin(status_pin));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; ext_ack = 0; rfsh_active = 0; rfsh_strobe = 0; rfsh_dis = 0; prog_load = 0;
    step(2);
    rst_n = 1;
  endtask

  task automatic edges_to_req(output int n);
    n = 0;
    do begin step(); n++; end while (!status_pin && n < 600);
  endtask

  initial begin
    int n;
    do_reset();
    check("R7 reset pin low", status_pin, 0);

    for (int N = 0; N <= 6; N++) begin
      interval = CW'(N); do_reset();
      edges_to_req(n);
      check("R1 first request", n, (N == 0) ? 1 : N);
    end

    interval = 10; do_reset(); rfsh_dis = 1;
    edges_to_req(n);
    check("R2 request while disabled", n, 10);
    rfsh_dis = 0;

    step(5);
    check("R4 request held", status_pin, 1);
    ext_ack = 1; step(); ext_ack = 0;
    check("R4 ack retires", status_pin, 0);

    do_reset(); step(10);
    rfsh_active = 1; step(); rfsh_active = 0; step();
    check("R4 internal refresh retires", status_pin, 0);

    for (int k = 1; k <= 10; k++) begin
      int acks;
      interval = 4; do_reset(); step(4 * k);
      interval = 255;
      acks = 0;
      while (status_pin && acks < 20) begin
        ext_ack = 1; step(); ext_ack = 0; acks++;
      end
      check("R5 backlog depth", acks, (k > 8) ? 8 : k);
    end

    interval = 10; do_reset(); step(5);
    rfsh_strobe = 1; step(3); rfsh_strobe = 0;
    edges_to_req(n);
    check("R6 qualified clear", n, 10);

    do_reset(); step(5);
    rfsh_strobe = 1; step(2); rfsh_strobe = 0;
    edges_to_req(n);
    check("R6 short pulse ignored", n, 3);

    do_reset(); step(5);
    rfsh_strobe = 1; step(7); rfsh_strobe = 0;
    edges_to_req(n);
    check("R6 held clear stays zero", n, 10);

    do_reset(); step(5);
    rfsh_dis = 1; rfsh_strobe = 1; step(3); rfsh_strobe = 0; rfsh_dis = 0;
    edges_to_req(n);
    check("R6 R2 no clear when disabled", n, 2);

    do_reset(); step(10);
    rfsh_strobe = 1; step(3); rfsh_strobe = 0;
    check("R6 clear keeps request", status_pin, 1);

    do_reset(); step(10);
    mode_in = 1; prog_load = 1; step(); prog_load = 0; mode_in = 0;
    check("R3 in-progress mode hides request", status_pin, 0);
    rfsh_active = 1; #1;
    check("R3 pin follows refresh active", status_pin, 1);
    step(); rfsh_active = 0; #1;
    check("R3 pin drops with refresh active", status_pin, 0);
    mode_in = 0; prog_load = 1; step(); prog_load = 0;
    check("R3 R4 request mode after service", status_pin, 0);

    do_reset(); step(10);
    check("R7 mode back to request after reset", status_pin, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule